// File: doc/BRIEF.md
# Round-Robin Masked Interrupt Dispatcher

This block gathers a set of internal interrupt request lines (32 or 64, chosen by parameter) and combines them with an enable mask that software builds one bit at a time. A line counts as pending only when its raw request and its enable bit are both high. A summary interrupt output rises whenever any line is pending. When the dispatcher is idle and something is pending, it picks one line to serve. It scans from a stored search pointer, so no line has a fixed priority over another. It then holds that choice on its outputs until the consumer acknowledges it.

A contiguous window of request bits can be declared as cascaded external lines. A selected bit inside that window is reported as an external index counted from the window's first bit, with an external flag set. Any other bit is reported by its own internal number.

The control is a two-state machine. In `ST_IDLE` the block offers nothing. On the transition *capture* (`ST_IDLE` to `ST_OFFER`, taken when any line is pending), the chosen line is latched. In `ST_OFFER` the latched choice is presented. On the transition *retire* (`ST_OFFER` to `ST_IDLE`, taken on acknowledge), the search pointer moves to the position just after the served line. In every other case the state holds.

Top module: `irq_rr_dispatch`

## Requirements
- R1: After reset the enable mask is all zeros, `irq_any` and `sel_valid` are low, and the search pointer is 0, so the first search starts at line 0.
- R2: `irq_any` is high in the same cycle whenever any bit of `raw_status & mask` is set, and low otherwise.
- R3: A write with `op_valid` high and `op_unmask` low clears only mask bit `op_line`. With `op_unmask` high it sets only that bit. All other mask bits keep their value.
- R4: While nothing is pending, no offer is made and the search pointer keeps its value.
- R5: The captured line is the first pending line found scanning upward from the pointer, wrapping modulo the line count.
- R6: An acknowledge during an offer ends it: `sel_valid` is low in the next cycle, the pointer becomes the served line plus one (modulo the line count), and a new search starts the cycle after.
- R7: While an offer is not acknowledged, `sel_valid`, `sel_num` and `sel_ext` hold steady, even if the raw requests change.
- R8: With cascading enabled, a served bit b in the inclusive range EXT_START to EXT_START+EXT_COUNT-1 is reported as `sel_ext`=1 and `sel_num`=b-EXT_START. Any other bit is reported as `sel_ext`=0 and `sel_num`=b.
- R9: Serving the highest line (NUM_LINES-1) wraps the pointer to line 0.
- R10: `sel_ack` has no effect while no offer is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_status | input | NUM_LINES | Raw interrupt request lines |
| op_valid | input | 1 | Mask update strobe |
| op_unmask | input | 1 | 1 sets (enables), 0 clears (disables) the addressed mask bit |
| op_line | input | IDX_W | Line number addressed by the mask update |
| irq_any | output | 1 | High while any enabled line is pending |
| sel_valid | output | 1 | An offer is presented |
| sel_ext | output | 1 | Offered line lies in the cascade window |
| sel_num | output | IDX_W | Internal line number, or external index when `sel_ext` is high |
| sel_ack | input | 1 | Consumer has served the offered line |

## Verification
The bench builds the block with 64 lines, cascading enabled, and a six-line window starting at bit 8. With 64 lines, the pointer wraps on the 6-bit boundary after serving line 63. With this window, both window edges (bits 8 and 13) and the bits just outside them (7, 14) can be reached. The same request pattern is applied repeatedly so that the rotating pointer alternates between lines below and above it. Directed cases cover masked lines, changing requests during a held offer, and stray acknowledges.

// File: rtl/irq_rr_pkg.sv
package irq_rr_pkg;

    // Dispatcher control states
    typedef enum logic [0:0] {
        ST_IDLE  = 1'b0,   // nothing offered, searching
        ST_OFFER = 1'b1    // a captured line is held until acknowledged
    } disp_state_e;

endpackage

// File: rtl/irq_mask_reg.sv
module irq_mask_reg #(
    parameter int NUM_LINES = 64,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 op_valid,
    input  logic                 op_unmask,
    input  logic [IDX_W-1:0]     op_line,
    output logic [NUM_LINES-1:0] mask_o
);

    logic [NUM_LINES-1:0] mask_q;
    logic [NUM_LINES-1:0] op_hot;

    assign op_hot = NUM_LINES'(1) << op_line;
    assign mask_o = mask_q;

    // Single-bit read-modify-write of the enable mask
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (op_valid) begin
            mask_q[op_line] <= op_unmask;
        end
    end

    // R3
    mask_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (mask_q[$past(op_line)] == $past(op_unmask)));

    // R3
    mask_others_chk: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (((mask_q ^ $past(mask_q)) & ~$past(op_hot)) == '0));

    // R3
    mask_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> $stable(mask_q));

endmodule

// File: rtl/irq_rr_pick.sv
module irq_rr_pick #(
    parameter int NUM_LINES = 64,
    parameter int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0] pend_i,
    input  logic [IDX_W-1:0]     ptr_i,
    output logic                 hit_o,
    output logic [IDX_W-1:0]     bit_o
);

    logic [2*NUM_LINES-1:0] doubled;
    logic [2*NUM_LINES-1:0] shifted;
    logic [NUM_LINES-1:0]   rotated;
    logic [IDX_W-1:0]       offset;

    // Rotate so that the pointer position lands on bit 0
    assign doubled = {pend_i, pend_i};
    assign shifted = doubled >> ptr_i;
    assign rotated = shifted[NUM_LINES-1:0];

    // Lowest set bit of the rotated vector wins
    always_comb begin
        offset = '0;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (rotated[i]) begin
                offset = IDX_W'(i);
            end
        end
    end

    // Rotate back: the add wraps naturally at the power-of-two width
    assign bit_o = ptr_i + offset;
    assign hit_o = |pend_i;

endmodule

// File: rtl/irq_cascade_map.sv
module irq_cascade_map #(
    parameter int NUM_LINES  = 64,
    parameter int IDX_W      = $clog2(NUM_LINES),
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_START  = 8,
    parameter int EXT_COUNT  = 6
) (
    input  logic [IDX_W-1:0] bit_i,
    output logic             ext_o,
    output logic [IDX_W-1:0] num_o
);

    localparam logic [IDX_W-1:0] WIN_LO = IDX_W'(EXT_START);
    localparam logic [IDX_W-1:0] WIN_HI = IDX_W'(EXT_START + EXT_COUNT - 1);

    generate
        if (CASCADE_EN) begin : g_window
            logic in_win;
            assign in_win = (bit_i >= WIN_LO) && (bit_i <= WIN_HI);
            assign ext_o  = in_win;
            assign num_o  = in_win ? (bit_i - WIN_LO) : bit_i;
        end else begin : g_flat
            assign ext_o = 1'b0;
            assign num_o = bit_i;
        end
    endgenerate

endmodule

// File: rtl/irq_rr_dispatch.sv
module irq_rr_dispatch
    import irq_rr_pkg::*;
#(
    parameter int NUM_LINES  = 64,
    parameter bit CASCADE_EN = 1'b1,
    parameter int EXT_START  = 8,
    parameter int EXT_COUNT  = 6,
    localparam int IDX_W     = $clog2(NUM_LINES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] raw_status,
    input  logic                 op_valid,
    input  logic                 op_unmask,
    input  logic [IDX_W-1:0]     op_line,
    output logic                 irq_any,
    output logic                 sel_valid,
    output logic                 sel_ext,
    output logic [IDX_W-1:0]     sel_num,
    input  logic                 sel_ack
);

    logic [NUM_LINES-1:0] mask;
    logic [NUM_LINES-1:0] pend;
    logic                 pick_hit;
    logic [IDX_W-1:0]     pick_bit;
    logic                 map_ext;
    logic [IDX_W-1:0]     map_num;

    disp_state_e      state_q, state_nx;
    logic [IDX_W-1:0] ptr_q;
    logic [IDX_W-1:0] held_bit;
    logic             held_ext;
    logic [IDX_W-1:0] held_num;

    irq_mask_reg #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_valid  (op_valid),
        .op_unmask (op_unmask),
        .op_line   (op_line),
        .mask_o    (mask)
    );

    assign pend    = raw_status & mask;
    assign irq_any = |pend;

    irq_rr_pick #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_pick (
        .pend_i (pend),
        .ptr_i  (ptr_q),
        .hit_o  (pick_hit),
        .bit_o  (pick_bit)
    );

    irq_cascade_map #(
        .NUM_LINES  (NUM_LINES),
        .IDX_W      (IDX_W),
        .CASCADE_EN (CASCADE_EN),
        .EXT_START  (EXT_START),
        .EXT_COUNT  (EXT_COUNT)
    ) u_map (
        .bit_i (pick_bit),
        .ext_o (map_ext),
        .num_o (map_num)
    );

    // State register, pointer and captured offer
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            ptr_q    <= '0;
            held_bit <= '0;
            held_ext <= 1'b0;
            held_num <= '0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_IDLE && pick_hit) begin
                held_bit <= pick_bit;
                held_ext <= map_ext;
                held_num <= map_num;
            end
            if (state_q == ST_OFFER && sel_ack) begin
                ptr_q <= held_bit + IDX_W'(1);
            end
        end
    end

    // Transitions: capture (IDLE->OFFER), retire (OFFER->IDLE)
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE:  if (pick_hit) state_nx = ST_OFFER;
            ST_OFFER: if (sel_ack)  state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        sel_valid = 1'b0;
        unique case (state_q)
            ST_IDLE:  sel_valid = 1'b0;
            ST_OFFER: sel_valid = 1'b1;
            default:  sel_valid = 1'b0;
        endcase
        sel_ext = held_ext;
        sel_num = held_num;
    end

    // R5
    pick_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pick_hit |-> pend[pick_bit]);

    // R4
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid && !irq_any) |=> (!sel_valid && $stable(ptr_q)));

    // R6
    retire_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_ack) |=> !sel_valid);

    // R7
    offer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && !sel_ack) |=> (sel_valid && $stable(sel_num) && $stable(sel_ext)));

    // R8
    ext_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_valid && sel_ext) |-> (int'(sel_num) < EXT_COUNT));

    // R10
    stray_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_valid && sel_ack) |=> $stable(ptr_q));

endmodule

// File: tb/sim_irq_rr_dispatch.sv
module sim_irq_rr_dispatch;

    localparam int N      = 64;
    localparam int W_LO   = 8;
    localparam int W_CNT  = 6;
    localparam int NVEC   = 10;

    // Request pattern and the line expected to be served, walked in order
    localparam logic [63:0] VRAW [0:NVEC-1] = '{
        64'h0000_0100_0000_0020, 64'h0000_0100_0000_0020, 64'h0000_0100_0000_0020,
        64'h0000_0000_0000_0400, 64'h0000_0000_0000_6000, 64'h0000_0000_0000_4100,
        64'h8000_0000_0000_0100, 64'h8000_0000_0000_0100, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0000_0000_0001
    };
    localparam int VBIT [0:NVEC-1] = '{5, 40, 5, 10, 13, 14, 63, 8, 9, 0};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  raw_status = '0;
    logic          op_valid = 1'b0;
    logic          op_unmask = 1'b0;
    logic [5:0]    op_line = '0;
    logic          irq_any;
    logic          sel_valid;
    logic          sel_ext;
    logic [5:0]    sel_num;
    logic          sel_ack = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    irq_rr_dispatch #(
        .NUM_LINES  (N),
        .CASCADE_EN (1'b1),
        .EXT_START  (W_LO),
        .EXT_COUNT  (W_CNT)
    ) u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .raw_status (raw_status),
        .op_valid   (op_valid),
        .op_unmask  (op_unmask),
        .op_line    (op_line),
        .irq_any    (irq_any),
        .sel_valid  (sel_valid),
        .sel_ext    (sel_ext),
        .sel_num    (sel_num),
        .sel_ack    (sel_ack)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    task automatic mask_op(input logic unmask, input int line);
        op_valid  = 1'b1;
        op_unmask = unmask;
        op_line   = 6'(line);
        @(posedge clk); @(negedge clk);
        op_valid  = 1'b0;
    endtask

    // Present a pattern, check the offer, acknowledge it (starts and ends at negedge)
    task automatic serve(input logic [63:0] r, input int b);
        int exp_num;
        logic exp_ext;
        exp_ext = (b >= W_LO) && (b <= W_LO + W_CNT - 1);
        exp_num = exp_ext ? b - W_LO : b;
        raw_status = r;
        #1;
        chk("R2 irq_any", 64'(irq_any), 64'(1));
        @(posedge clk); @(negedge clk);
        chk("R5 valid", 64'(sel_valid), 64'(1));
        chk("R5 num", 64'(sel_num), 64'(exp_num));
        chk("R8 ext", 64'(sel_ext), 64'(exp_ext));
        sel_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        sel_ack = 1'b0;
        raw_status = '0;
        chk("R6 drop", 64'(sel_valid), 64'(0));
    endtask

    initial begin
        #(8 * 100000);
        n_fail++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        // R1: reset state, mask all zeros
        raw_status = '1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 irq_any", 64'(irq_any), 64'(0));
        chk("R1 valid", 64'(sel_valid), 64'(0));
        @(posedge clk); @(negedge clk);
        chk("R1 valid later", 64'(sel_valid), 64'(0));
        raw_status = '0;

        // Enable every line
        for (int i = 0; i < N; i++) mask_op(1'b1, i);

        // R5 R8 R9: table walk, pointer starts at 0 (R1)
        for (int k = 0; k < NVEC; k++) serve(VRAW[k], VBIT[k]);

        // R4: nothing pending, no offer, pointer kept at 1
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R4 no offer", 64'(sel_valid), 64'(0));
            chk("R4 irq_any", 64'(irq_any), 64'(0));
        end
        serve(64'h3, 1);

        // R10: stray acknowledge while idle, pointer stays 2
        sel_ack = 1'b1;
        repeat (2) begin @(posedge clk); @(negedge clk); end
        sel_ack = 1'b0;
        chk("R10 no offer", 64'(sel_valid), 64'(0));
        serve(64'hD, 2);

        // R7: offer of line 20 held while requests change
        raw_status = 64'h1 << 20;
        @(posedge clk); @(negedge clk);
        chk("R7 valid", 64'(sel_valid), 64'(1));
        chk("R7 num", 64'(sel_num), 64'(20));
        raw_status = 64'h1 << 30;
        for (int i = 0; i < 3; i++) begin
            @(posedge clk); @(negedge clk);
            chk("R7 hold valid", 64'(sel_valid), 64'(1));
            chk("R7 hold num", 64'(sel_num), 64'(20));
            chk("R7 hold ext", 64'(sel_ext), 64'(0));
        end
        sel_ack = 1'b1;
        @(posedge clk); @(negedge clk);
        sel_ack = 1'b0;
        raw_status = '0;

        // R3: mask line 30 only
        mask_op(1'b0, 30);
        raw_status = 64'h1 << 30;
        #1;
        chk("R3 masked irq_any", 64'(irq_any), 64'(0));
        @(posedge clk); @(negedge clk);
        chk("R3 masked no offer", 64'(sel_valid), 64'(0));
        serve((64'h1 << 31) | (64'h1 << 30), 31);
        mask_op(1'b1, 30);
        serve(64'h1 << 30, 30);
        // R3: bit 7 just below the window still enabled, R8 edge
        serve(64'h80, 7);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule